// File: doc/BRIEF.md
# Receive-Side Destination Filter with Frame Reject Strobe

This block sits beside one nibble-wide media-independent receive channel and decides, while the frame is still arriving, whether the MAC should throw it away. It hunts for the start-of-frame delimiter, gathers the twelve nibbles of the destination address that follow it, and compares that address with a small register table of programmed station addresses. A frame whose destination hits no valid table slot is refused. The block refuses a frame by driving a reject strobe early enough in the frame for the MAC to act on it.

The refusal takes two forms. The first is a reject strobe of fixed minimum length whose active level is chosen by a configuration bit. The second is a forced receive-error line that merges the internal refusal with the receive error reported by the PHY, so a MAC with no reject input still drops the frame. The address table is written one slot at a time through a simple index/data/write-enable port. Every slot carries its own valid bit.

Top module: `rx_reject_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no refusal is active: `rej_o` equals `cfg_rej_active_low` and `force_err_o` equals `rx_er`.
- R2: The delimiter is a nibble of value 0x5 followed directly by a nibble of value 0xD, both with `rx_dv` high. The twelve nibbles after it form the destination address, and address nibble k (counting from 0) fills bits 4k+3..4k.
- R3: A frame whose destination address equals the address of a table slot marked valid is never refused.
- R4: A frame whose complete destination address matches no valid slot is refused. The refusal becomes active at the clock edge that samples the twelfth address nibble.
- R5: Each refusal stays active for exactly `PULSE_CYCLES` (default 3) clock cycles, which is 120 ns at a 25 MHz receive clock. It runs to its full length even when `rx_dv` falls during it.
- R6: A refusal starts between 1 and `WIN_MAX_NIBS` (default 128, that is 512 bit times) nibbles after the delimiter.
- R7: With `cfg_rej_active_low` = 0, `rej_o` is high while a refusal is active. With it at 1, the output is inverted and `rej_o` is low while a refusal is active.
- R8: `force_err_o` is high exactly when `rx_er` is high or a refusal is active, whatever the output polarity.
- R9: If `rx_dv` falls before the twelfth address nibble, the frame is dropped with no refusal. Whenever `rx_dv` is low, the tracker returns to idle.
- R10: A write with `tbl_wr_en` high loads slot `tbl_wr_idx` with `tbl_wr_valid` and `tbl_wr_mac`, and the new contents apply to later frames. A slot with its valid bit clear matches nothing. All slots come out of reset invalid, so every frame is refused until a slot is loaded.
- R11: Each frame gets at most one decision. Nibbles after the address, even a 0x5 followed by 0xD, do not start a new decision, and a 0xD not directly preceded by 0x5 is not a delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid, high for the whole frame |
| rx_er | input | 1 | Receive error from the PHY |
| cfg_rej_active_low | input | 1 | 1 makes `rej_o` active low |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | $clog2(TBL_DEPTH) | Table slot being written |
| tbl_wr_valid | input | 1 | Valid bit written into the slot |
| tbl_wr_mac | input | 48 | Station address written into the slot |
| rej_o | output | 1 | Reject strobe, polarity set by configuration |
| force_err_o | output | 1 | Receive error merged with refusal, active high |

## Verification
Each of the eight slots is first hit by an exact address, which shows that accepted frames stay silent. Then every one of the 48 address bits is flipped in turn, which separates a full-width compare from one that ignores some nibbles. An address sent most significant nibble first, and leading junk that contains a lone 0xD, show whether the nibble order and the delimiter pairing are right. Frames cut short after each possible number of address nibbles show whether the block refuses too early. A frame cut right after the last nibble shows that the strobe holds its full width. Both polarities are run with `rx_er` toggled in the payload, which shows whether the merged error line follows the refusal rather than the pin level.

// File: rtl/rrc_pkg.sv
`timescale 1ns/1ps
package rrc_pkg;

    localparam int NIB_W     = 4;
    localparam int MAC_W     = 48;
    localparam int ADDR_NIBS = MAC_W / NIB_W;
    localparam int SH_W      = MAC_W - NIB_W;

    localparam logic [NIB_W-1:0] SFD_LEAD = 4'h5;
    localparam logic [NIB_W-1:0] SFD_MARK = 4'hD;

    typedef logic [NIB_W-1:0] nibble_t;
    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HUNT,
        RX_ADDR,
        RX_DONE
    } rx_phase_e;

    typedef struct packed {
        logic valid;
        mac_t mac;
    } tbl_entry_t;

    typedef struct packed {
        logic last;
        mac_t addr;
    } addr_probe_t;

    // New nibble enters at the top; after ADDR_NIBS shifts the first one sits at bit 0.
    function automatic mac_t shift_in(input logic [SH_W-1:0] sh, input nibble_t nib);
        return {nib, sh};
    endfunction

    function automatic logic entry_hit(input tbl_entry_t e, input mac_t a);
        return e.valid && (e.mac == a);
    endfunction

    function automatic logic is_sfd(input nibble_t prev, input nibble_t cur);
        return (prev == SFD_LEAD) && (cur == SFD_MARK);
    endfunction

endpackage

// File: rtl/rrc_frame_tracker.sv
`timescale 1ns/1ps
module rrc_frame_tracker
    import rrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  nibble_t     rxd,
    input  logic        rx_dv,
    output addr_probe_t probe,
    output logic        sfd_hit
);

    localparam int CNT_W = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_NIBS - 1);

    rx_phase_e        phase_q;
    nibble_t          prev_q;
    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hunting;

    assign hunting = (phase_q == RX_IDLE) || (phase_q == RX_HUNT);
    assign sfd_hit = hunting && rx_dv && is_sfd(prev_q, rxd);

    always_comb begin
        probe.addr = shift_in(sh_q, rxd);
        probe.last = (phase_q == RX_ADDR) && rx_dv && (cnt_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RX_IDLE;
            prev_q  <= '0;
            sh_q    <= '0;
            cnt_q   <= '0;
        end else if (!rx_dv) begin
            phase_q <= RX_IDLE;
            prev_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                RX_IDLE, RX_HUNT: begin
                    prev_q <= rxd;
                    if (sfd_hit) begin
                        phase_q <= RX_ADDR;
                        cnt_q   <= '0;
                    end else begin
                        phase_q <= RX_HUNT;
                    end
                end
                RX_ADDR: begin
                    sh_q <= probe.addr[MAC_W-1:NIB_W];
                    if (probe.last) begin
                        phase_q <= RX_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= RX_DONE;
            endcase
        end
    end

    // R9: a low data-valid always sends the tracker back to idle
    assert_idle_on_dv_low_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_dv |=> (phase_q == RX_IDLE));

    // R2: a delimiter starts address collection at nibble zero
    assert_sfd_starts_addr_R2: assert property (@(posedge clk) disable iff (rst)
        sfd_hit |=> (phase_q == RX_ADDR) && (cnt_q == '0));

    // R11: once the address is complete no further decision is prepared
    assert_single_decision_R11: assert property (@(posedge clk) disable iff (rst)
        probe.last |=> (phase_q == RX_DONE));

endmodule

// File: rtl/rrc_addr_table.sv
`timescale 1ns/1ps
module rrc_addr_table
    import rrc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  tbl_entry_t               wr_entry,
    input  mac_t                     probe_addr,
    output logic                     hit
);

    localparam int IDX_W = $clog2(DEPTH);

    tbl_entry_t       tbl_q [DEPTH];
    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tbl_q[g] <= wr_entry;
            end
        end
        assign hit_vec[g] = entry_hit(tbl_q[g], probe_addr);
    end

    assign hit = |hit_vec;

    // R10: a write lands in the addressed slot on the next edge
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/rrc_reject_pulse.sv
`timescale 1ns/1ps
module rrc_reject_pulse #(
    parameter int PULSE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic rx_er,
    input  logic active_low,
    output logic active_o,
    output logic reject_o,
    output logic force_err_o
);

    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYCLES - 1);

    logic             act_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            act_q  <= 1'b1;
            left_q <= RELOAD;
        end else if (act_q) begin
            if (left_q == '0) begin
                act_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign active_o    = act_q;
    assign reject_o    = act_q ^ active_low;
    assign force_err_o = act_q | rx_er;

    // Checker: length of the current active run, saturating
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!act_q) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5: every pulse lasts exactly PULSE_CYCLES cycles
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(act_q) |-> (run_q == RUN_W'(PULSE_CYCLES)));

endmodule

// File: rtl/rx_reject_ctrl.sv
`timescale 1ns/1ps
module rx_reject_ctrl
    import rrc_pkg::*;
#(
    parameter int TBL_DEPTH    = 8,
    parameter int PULSE_CYCLES = 3,
    parameter int WIN_MAX_NIBS = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [3:0]                   rxd,
    input  logic                         rx_dv,
    input  logic                         rx_er,
    input  logic                         cfg_rej_active_low,
    input  logic                         tbl_wr_en,
    input  logic [$clog2(TBL_DEPTH)-1:0] tbl_wr_idx,
    input  logic                         tbl_wr_valid,
    input  logic [47:0]                  tbl_wr_mac,
    output logic                         rej_o,
    output logic                         force_err_o
);

    addr_probe_t probe;
    logic        sfd_hit;
    logic        hit;
    logic        fire;
    logic        rej_active;
    tbl_entry_t  wr_entry;

    assign wr_entry.valid = tbl_wr_valid;
    assign wr_entry.mac   = tbl_wr_mac;

    rrc_frame_tracker u_tracker (
        .clk     (clk),
        .rst     (rst),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .probe   (probe),
        .sfd_hit (sfd_hit)
    );

    rrc_addr_table #(
        .DEPTH (TBL_DEPTH)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_wr_en),
        .wr_idx     (tbl_wr_idx),
        .wr_entry   (wr_entry),
        .probe_addr (probe.addr),
        .hit        (hit)
    );

    assign fire = probe.last && !hit;

    rrc_reject_pulse #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .rx_er       (rx_er),
        .active_low  (cfg_rej_active_low),
        .active_o    (rej_active),
        .reject_o    (rej_o),
        .force_err_o (force_err_o)
    );

    // Checker: nibbles seen since the last delimiter, saturating
    localparam int WCNT_W = $clog2(WIN_MAX_NIBS + 1) + 1;
    logic [WCNT_W-1:0] win_cnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt_q <= '1;
        end else if (sfd_hit) begin
            win_cnt_q <= '0;
        end else if (rx_dv && (win_cnt_q != '1)) begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    // R6: a refusal begins inside the window the MAC can still honour
    assert_reject_window_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rej_active) |-> (win_cnt_q >= WCNT_W'(1)) && (win_cnt_q <= WCNT_W'(WIN_MAX_NIBS)));

    // R4: a refusal only starts from a completed, unmatched address
    assert_reject_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rej_active) |-> $past(probe.last && !hit));

    // R3: a matched address never starts a refusal
    assert_match_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (probe.last && hit && !rej_active) |=> !rej_active);

    // R8: the strobe pin being active implies the merged error is raised
    assert_force_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (rej_o != cfg_rej_active_low) |-> force_err_o);

endmodule

// File: tb/rx_reject_ctrl_bench.sv
`timescale 1ns/1ps
module rx_reject_ctrl_bench;

    localparam int DEPTH = 8;
    localparam int PULSE = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rxd;
    logic        rx_dv;
    logic        rx_er;
    logic        cfg_low;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic        wr_valid;
    logic [47:0] wr_mac;
    logic        rej_o;
    logic        force_o;

    always #2.5 clk = ~clk;

    rx_reject_ctrl u_rx_reject_ctrl (
        .clk                (clk),
        .rst                (rst),
        .rxd                (rxd),
        .rx_dv              (rx_dv),
        .rx_er              (rx_er),
        .cfg_rej_active_low (cfg_low),
        .tbl_wr_en          (wr_en),
        .tbl_wr_idx         (wr_idx),
        .tbl_wr_valid       (wr_valid),
        .tbl_wr_mac         (wr_mac),
        .rej_o              (rej_o),
        .force_err_o        (force_o)
    );

    int checks = 0;
    int fails  = 0;

    logic        bvalid [DEPTH];
    logic [47:0] bmac   [DEPTH];

    int tag, rej_cycles, first_idx, ferr_bad;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] mac_of(input int i);
        return 48'h025A_3C10_71E0 + 48'(i) * 48'h0000_0101_0011;
    endfunction

    function automatic bit model_reject(input logic [47:0] a);
        for (int i = 0; i < DEPTH; i++)
            if (bvalid[i] && bmac[i] == a) return 1'b0;
        return 1'b1;
    endfunction

    // Sample mid-cycle, then drive the next nibble
    task automatic tick(input logic [3:0] d, input logic dv, input logic er);
        logic act;
        @(negedge clk);
        act = (rej_o !== cfg_low);
        if (act) begin
            rej_cycles++;
            if (first_idx < 0) first_idx = tag - 1;
        end
        if (force_o !== (rx_er | act)) ferr_bad++;
        rxd = d; rx_dv = dv; rx_er = er; tag++;
    endtask

    task automatic tbl_write(input int idx, input logic v, input logic [47:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_valid = v; wr_mac = m;
        @(negedge clk);
        wr_en = 1'b0;
        bvalid[idx] = v; bmac[idx] = m;
    endtask

    task automatic frame(input logic [47:0] mac, input int pre_n, input int addr_n,
                         input int pay_n, input bit junk, input bit rev, input bit er_pay,
                         input string req);
        logic [47:0] seen;
        int base;
        bit exp_rej;
        tag = 0; rej_cycles = 0; first_idx = -1; ferr_bad = 0;
        base = 0;
        if (junk) begin
            tick(4'hA, 1'b1, 1'b0);
            tick(4'hD, 1'b1, 1'b0);
            base = 2;
        end
        for (int p = 0; p < pre_n; p++) tick(4'h5, 1'b1, 1'b0);
        tick(4'hD, 1'b1, 1'b0);
        for (int k = 0; k < 12; k++) begin
            seen[4*k +: 4] = rev ? mac[4*(11-k) +: 4] : mac[4*k +: 4];
        end
        for (int k = 0; k < addr_n; k++) tick(seen[4*k +: 4], 1'b1, 1'b0);
        for (int j = 0; j < pay_n; j++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // payload carries delimiter-like pairs now and then (R11)
            tick((j % 7 == 0) ? 4'h5 : (j % 7 == 1) ? 4'hD : lfsr[3:0], 1'b1, er_pay && (j % 3 == 0));
        end
        for (int g = 0; g < 8; g++) tick(4'h0, 1'b0, 1'b0);
        exp_rej = (addr_n == 12) && model_reject(seen);
        if (exp_rej) begin
            chk(rej_cycles == PULSE, "R5", {req, " pulse length"}, rej_cycles, PULSE);
            chk(first_idx == base + pre_n + 12, "R4", {req, " pulse start"}, first_idx, base + pre_n + 12);
            // R6: start is 12 nibbles (48 bit times) after the delimiter
            chk((first_idx - (base + pre_n)) >= 1 && (first_idx - (base + pre_n)) <= 128, "R6",
                {req, " window"}, first_idx - (base + pre_n), 12);
        end else begin
            chk(rej_cycles == 0, req, "unexpected refusal cycles", rej_cycles, 0);
        end
        chk(ferr_bad == 0, "R8", {req, " forced error mismatches"}, ferr_bad, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; rxd = '0; rx_dv = 1'b0; rx_er = 1'b0; cfg_low = 1'b0;
        wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_mac = '0;
        for (int i = 0; i < DEPTH; i++) begin bvalid[i] = 1'b0; bmac[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rej_o == 1'b0, "R1", "reject after reset", rej_o, 0);
        chk(force_o == 1'b0, "R1", "forced error after reset", force_o, 0);
        rx_er = 1'b1;
        #1;
        chk(force_o == 1'b1, "R8", "forced error follows rx_er", force_o, 1);
        rx_er = 1'b0;
        cfg_low = 1'b1;
        #1;
        chk(rej_o == 1'b1, "R7", "idle level when active low", rej_o, 1);
        cfg_low = 1'b0;

        // R10: empty table refuses everything
        frame(mac_of(0), 7, 12, 10, 0, 0, 0, "R10");

        for (int i = 0; i < DEPTH; i++) tbl_write(i, 1'b1, mac_of(i));

        // R3: each slot accepts its own address
        for (int i = 0; i < DEPTH; i++) frame(mac_of(i), 1 + i, 12, 6, 0, 0, 0, "R3");

        // R4: every single-bit flip of a stored address is refused
        for (int b = 0; b < 48; b++)
            frame(mac_of(b % DEPTH) ^ (48'h1 << b), 3, 12, 4, 0, 0, 0, "R4");

        // R2: most-significant-nibble-first order must not match
        frame(mac_of(2), 5, 12, 4, 0, 1, 0, "R2");
        // R11: lone 0xD before the preamble, long payload with 5,D pairs
        frame(mac_of(5), 4, 12, 40, 1, 0, 0, "R11");
        frame(48'hFFFF_0000_1234, 4, 12, 40, 0, 0, 0, "R11");

        // R10: invalidate, revalidate and overwrite slots
        tbl_write(3, 1'b0, mac_of(3));
        frame(mac_of(3), 3, 12, 4, 0, 0, 0, "R10");
        tbl_write(3, 1'b1, mac_of(3));
        frame(mac_of(3), 3, 12, 4, 0, 0, 0, "R10");
        tbl_write(4, 1'b1, 48'h1111_2222_3333);
        frame(mac_of(4), 3, 12, 4, 0, 0, 0, "R10");
        frame(48'h1111_2222_3333, 3, 12, 4, 0, 0, 0, "R10");

        // R7 and R8: inverted polarity with receive errors in the payload
        cfg_low = 1'b1;
        frame(mac_of(1), 6, 12, 12, 0, 0, 1, "R7");
        frame(mac_of(1) ^ 48'h80, 6, 12, 12, 0, 0, 1, "R7");
        cfg_low = 1'b0;
        frame(mac_of(6) ^ 48'h4, 6, 12, 12, 0, 0, 1, "R8");

        // R9: abandon after each possible short address length
        for (int k = 0; k < 12; k++) frame(48'hDEAD_BEEF_0000, 2, k, 0, 0, 0, 0, "R9");
        // R5: data valid falls right after the last address nibble
        frame(48'hDEAD_BEEF_0000, 2, 12, 0, 0, 0, 0, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule